// File: doc/BRIEF.md
# Serial Flash Power-Down and Signature Responder

This block is the slave-side command logic of a serial NOR flash. It serves three commands: entry into deep power-down, release from deep power-down combined with an 8-bit electronic signature readout, and clearing of the two failure flags in the status register. The SPI pins (select, serial clock, data in) are oversampled by the system clock. The block decodes the opcode, counts dummy bytes, shifts out the signature and tracks the power mode, including the timed wake-up.

The serial output comes as a data bit and an output-enable. The pad ring turns the enable into the high-impedance control. The signature is a constant input. A busy input from the program/erase engine blocks the commands while an internal operation runs. The erase-fail and program-fail flags are held here and are set by pulses from that engine. The write-enable latch is a pass-through input that appears in the status byte.

Top module: `flash_pd_sig_responder`

## Requirements
- R1: The output enable stays low while the opcode and the dummy bytes are being received, and whenever select is high.
- R2: Opcode 0xAB is followed by exactly 3 dummy bytes. After them the signature is sent MSB first. A new bit is driven after each falling SCK edge, so the host can sample it on the next rising edge. Data in is sampled on rising SCK edges.
- R3: While select stays low after the signature, further SCK cycles send the signature again, byte after byte.
- R4: After reset the block is in standby (power_down_o low). A complete opcode 0xB9 followed by a rise of select puts it into deep power-down (power_down_o high).
- R5: In deep power-down every opcode other than 0xAB is ignored. In particular, 0x30 leaves the fail flags set.
- R6: A rise of select that ends an accepted 0xAB frame in deep power-down starts a wake-up delay of WAKE_CYC system clocks, counted from the rise seen at the pins plus a few synchronizer cycles. At the end of the delay wake_done_o pulses for one cycle and power_down_o falls. power_down_o stays high during the delay.
- R7: 0xAB is accepted in standby too. It returns the signature, and no wake-up delay or wake_done_o pulse follows.
- R8: While busy_i is high at the end of an opcode, 0xAB, 0xB9 and 0x30 are all ignored. No signature is driven, the power mode does not change and the flags are kept.
- R9: Opcode 0x30 clears status bit 6 (program fail) and bit 5 (erase fail). It needs no write enable. Status bit 1 (write-enable latch) and bit 0 (busy) are unchanged.
- R10: If select rises before all 8 opcode bits have arrived, the command is dropped and the power mode is unchanged.
- R11: An opcode that is not one of the three has no effect on the power mode, the flags or the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_en | output | 1 | Output enable of spi_so (low means high impedance) |
| sig_value | input | 8 | Electronic signature constant |
| busy_i | input | 1 | Program/erase/register-write in progress |
| wel_i | input | 1 | Write-enable latch, shown as status bit 1 |
| erase_fail_set | input | 1 | Pulse that sets the erase-fail flag |
| prog_fail_set | input | 1 | Pulse that sets the program-fail flag |
| status_o | output | 8 | Status byte: bit 6 program fail, bit 5 erase fail, bit 1 WEL, bit 0 busy |
| power_down_o | output | 1 | Deep power-down mode, held through the wake-up delay |
| wake_busy_o | output | 1 | Wake-up delay running |
| wake_done_o | output | 1 | One-cycle pulse when the wake-up delay ends |

## Verification
The bench reads several signature bytes in one frame. A design that stops after one byte, or that loses its bit index at the byte wrap, sends a wrong second byte. The wake-up is timed against the select rise and checked at its midpoint. A design that leaves power-down at once, or never, fails the window check. Other cases cover a select rise after four opcode bits, 0x30 and 0xB9 sent while in power-down, and all three commands sent while busy. A design that commits a partial opcode, lets filtered commands through, or ignores busy would change the power mode, the flags or the output enable.

// File: rtl/fpd_pkg.sv
`timescale 1ns/1ps
package fpd_pkg;
  localparam int unsigned OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_RELEASE = 8'hAB;
  localparam logic [OPC_W-1:0] OPC_DEEP_PD = 8'hB9;
  localparam logic [OPC_W-1:0] OPC_CLR_FAIL = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_DUMMY,
    ST_SIG,
    ST_SKIP
  } cmd_state_e;
endpackage

// File: rtl/fpd_pin_sync.sv
`timescale 1ns/1ps
module fpd_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic si_pin,
  output logic cs_s,
  output logic si_s,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] stage_q [STAGES];
  logic            cs_d_q;
  logic            sck_d_q;
  logic [NPIN-1:0] synced;

  assign pins = {cs_n_pin, sck_pin, si_pin};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= pins;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign synced = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b1;
    end else begin
      cs_d_q  <= synced[2];
      sck_d_q <= synced[1];
    end
  end

  assign cs_s     = synced[2];
  assign si_s     = synced[0];
  assign cs_rise  = synced[2] & ~cs_d_q;
  assign sck_rise = synced[1] & ~sck_d_q;
  assign sck_fall = ~synced[1] & sck_d_q;
endmodule

// File: rtl/fpd_cmd_engine.sv
`timescale 1ns/1ps
module fpd_cmd_engine
  import fpd_pkg::*;
#(
  parameter int unsigned DUMMY_BYTES = 3,
  parameter int unsigned SIG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             si_s,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             busy_i,
  input  logic             pd_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic             so_o,
  output logic             so_en_o,
  output logic             clr_fail_o,
  output logic             enter_pd_o,
  output logic             wake_req_o
);
  localparam int unsigned DUMMY_BITS = DUMMY_BYTES * 8;
  localparam int unsigned MAX_BITS   = (DUMMY_BITS > OPC_W) ? DUMMY_BITS : OPC_W;
  localparam int unsigned CNT_W      = $clog2(MAX_BITS);
  localparam int unsigned IDX_W      = (SIG_W > 1) ? $clog2(SIG_W) : 1;
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(OPC_W - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP    = IDX_W'(SIG_W - 1);

  cmd_state_e       state_q, state_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [OPC_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             so_q, so_d;
  logic             oe_q, oe_d;
  logic             dp_arm_q, dp_arm_d;
  logic             res_arm_q, res_arm_d;
  logic             clr_d;
  logic [OPC_W-1:0] opc_full;

  assign opc_full = {sh_q[OPC_W-2:0], si_s};

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    idx_d     = idx_q;
    so_d      = so_q;
    oe_d      = oe_q;
    dp_arm_d  = dp_arm_q;
    res_arm_d = res_arm_q;
    clr_d     = 1'b0;
    if (cs_s) begin
      state_d   = ST_IDLE;
      bit_d     = '0;
      oe_d      = 1'b0;
      dp_arm_d  = 1'b0;
      res_arm_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_OPC;
          bit_d   = '0;
        end
        ST_OPC: begin
          if (sck_rise) begin
            sh_d = opc_full;
            if (bit_q == OPC_LAST) begin
              bit_d   = '0;
              state_d = ST_SKIP;
              if (!busy_i) begin
                if (opc_full == OPC_RELEASE) begin
                  state_d   = ST_DUMMY;
                  res_arm_d = 1'b1;
                end else if (!pd_i) begin
                  if (opc_full == OPC_DEEP_PD)       dp_arm_d = 1'b1;
                  else if (opc_full == OPC_CLR_FAIL) clr_d    = 1'b1;
                end
              end
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
        ST_DUMMY: begin
          if (sck_rise) begin
            if (bit_q == DUMMY_LAST) begin
              bit_d   = '0;
              idx_d   = IDX_TOP;
              state_d = ST_SIG;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
        ST_SIG: begin
          if (sck_fall) begin
            so_d  = sig_i[idx_q];
            oe_d  = 1'b1;
            idx_d = (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
      dp_arm_q  <= 1'b0;
      res_arm_q <= 1'b0;
      clr_fail_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      idx_q     <= idx_d;
      so_q      <= so_d;
      oe_q      <= oe_d;
      dp_arm_q  <= dp_arm_d;
      res_arm_q <= res_arm_d;
      clr_fail_o <= clr_d;
    end
  end

  assign so_o       = so_q;
  assign so_en_o    = oe_q;
  assign enter_pd_o = cs_rise & dp_arm_q;
  assign wake_req_o = cs_rise & res_arm_q;

  // R1
  oe_only_in_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (state_q == ST_SIG));

  // R8
  busy_blocks_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && state_q == ST_OPC && sck_rise && bit_q == OPC_LAST && busy_i)
      |=> (!dp_arm_q && !res_arm_q && !clr_fail_o));

  // R10
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && state_q == ST_OPC) |-> (!enter_pd_o && !wake_req_o));
endmodule

// File: rtl/fpd_power_ctl.sv
`timescale 1ns/1ps
module fpd_power_ctl #(
  parameter int unsigned WAKE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_pd_i,
  input  logic wake_req_i,
  output logic pd_o,
  output logic waking_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          pd_q, pd_d;
  logic          wake_q, wake_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    pd_d   = pd_q;
    wake_d = wake_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (wake_q) begin
      if (cnt_q <= ONE) begin
        pd_d   = 1'b0;
        wake_d = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (pd_q && wake_req_i) begin
      wake_d = 1'b1;
      cnt_d  = LOAD;
    end else if (!pd_q && enter_pd_i) begin
      pd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      wake_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pd_q   <= pd_d;
      wake_q <= wake_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign pd_o     = pd_q;
  assign waking_o = wake_q;
  assign done_o   = done_q;

  // R4
  pd_entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(enter_pd_i));

  // R6
  pd_exit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> done_q);

  // R6
  wake_holds_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> pd_q);
endmodule

// File: rtl/fpd_fail_flags.sv
`timescale 1ns/1ps
module fpd_fail_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic erase_set_i,
  input  logic prog_set_i,
  output logic erase_fail_o,
  output logic prog_fail_o
);
  logic efail_q, efail_d;
  logic pfail_q, pfail_d;

  always_comb begin
    efail_d = efail_q | erase_set_i;
    pfail_d = pfail_q | prog_set_i;
    if (clr_i) begin
      efail_d = 1'b0;
      pfail_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      efail_q <= 1'b0;
      pfail_q <= 1'b0;
    end else begin
      efail_q <= efail_d;
      pfail_q <= pfail_d;
    end
  end

  assign erase_fail_o = efail_q;
  assign prog_fail_o  = pfail_q;

  // R9
  efail_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(efail_q) |-> $past(clr_i));

  // R9
  pfail_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfail_q) |-> $past(clr_i));
endmodule

// File: rtl/flash_pd_sig_responder.sv
`timescale 1ns/1ps
module flash_pd_sig_responder #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DUMMY_BYTES = 3,
  parameter int unsigned SIG_W       = 8,
  parameter int unsigned WAKE_CYC    = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_si,
  output logic             spi_so,
  output logic             spi_so_en,
  input  logic [SIG_W-1:0] sig_value,
  input  logic             busy_i,
  input  logic             wel_i,
  input  logic             erase_fail_set,
  input  logic             prog_fail_set,
  output logic [7:0]       status_o,
  output logic             power_down_o,
  output logic             wake_busy_o,
  output logic             wake_done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cs_s, si_s, cs_rise, sck_rise, sck_fall;
  logic       clr_fail, enter_pd, wake_req, pd;
  logic       efail, pfail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fpd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .cs_n_pin(spi_cs_n), .sck_pin(spi_sck), .si_pin(spi_si),
    .cs_s(cs_s), .si_s(si_s), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  fpd_cmd_engine #(.DUMMY_BYTES(DUMMY_BYTES), .SIG_W(SIG_W)) u_cmd (
    .clk(clk), .rst_n(rst_int_n),
    .cs_s(cs_s), .si_s(si_s), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .busy_i(busy_i), .pd_i(pd), .sig_i(sig_value),
    .so_o(spi_so), .so_en_o(spi_so_en),
    .clr_fail_o(clr_fail), .enter_pd_o(enter_pd), .wake_req_o(wake_req)
  );

  fpd_power_ctl #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_int_n),
    .enter_pd_i(enter_pd), .wake_req_i(wake_req),
    .pd_o(pd), .waking_o(wake_busy_o), .done_o(wake_done_o)
  );

  fpd_fail_flags u_flags (
    .clk(clk), .rst_n(rst_int_n),
    .clr_i(clr_fail), .erase_set_i(erase_fail_set), .prog_set_i(prog_fail_set),
    .erase_fail_o(efail), .prog_fail_o(pfail)
  );

  assign power_down_o = pd;
  assign status_o     = {1'b0, pfail, efail, 3'b000, wel_i, busy_i};

  // R1
  so_quiet_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_s && $past(cs_s)) |-> !spi_so_en);

  // R5
  pd_filter_clr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pd && $past(pd) && !$past(erase_fail_set) && !$past(prog_fail_set))
      |-> ($stable(efail) && $stable(pfail)));
endmodule

// File: tb/test_flash_pd_sig_responder.sv
`timescale 1ns/1ps
module test_flash_pd_sig_responder;
  localparam int WAKE = 40;
  localparam time HALF = 64ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
  logic       spi_so, spi_so_en;
  logic [7:0] sig_value = 8'h16;
  logic       busy_i = 1'b0, wel_i = 1'b0;
  logic       erase_fail_set = 1'b0, prog_fail_set = 1'b0;
  logic [7:0] status_o;
  logic       power_down_o, wake_busy_o, wake_done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycle   = 0;
  int done_cnt = 0;
  int done_cycle = 0;
  int cs_cycle = 0;
  bit rd_active = 1'b0;
  logic [7:0] exp_q [$];
  logic [7:0] mon_sh = 8'h00;
  int mon_n = 0;

  always #4ns clk = ~clk;

  flash_pd_sig_responder i_flash_pd_sig_responder (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_en(spi_so_en),
    .sig_value(sig_value), .busy_i(busy_i), .wel_i(wel_i),
    .erase_fail_set(erase_fail_set), .prog_fail_set(prog_fail_set),
    .status_o(status_o), .power_down_o(power_down_o),
    .wake_busy_o(wake_busy_o), .wake_done_o(wake_done_o)
  );

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (rst_n && wake_done_o) begin
      done_cnt   <= done_cnt + 1;
      done_cycle <= cycle;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: host samples SO on rising SCK
  always @(posedge spi_sck) begin
    if (rd_active) begin
      chk(spi_so_en == 1'b1, "R2", "so_en during readout", spi_so_en, 1);
      mon_sh = {mon_sh[6:0], spi_so};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected byte", mon_sh, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(mon_sh == e, "R3", "signature byte", mon_sh, e);
        end
      end
    end
  end

  task automatic bit_out(input logic b);
    spi_si = b;
    #HALF; spi_sck = 1'b1;
    #HALF; spi_sck = 1'b0;
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_high();
    #HALF;
    spi_cs_n = 1'b1;
    cs_cycle = cycle;
    #(HALF * 2);
  endtask

  task automatic cmd(input logic [7:0] opc);
    cs_low();
    byte_out(opc);
    cs_high();
  endtask

  // signature read frame; nread bytes clocked after the dummies
  task automatic res_frame(input int nread, input bit expect_data);
    cs_low();
    byte_out(8'hAB);
    chk(spi_so_en == 1'b0, "R1", "so_en after opcode", spi_so_en, 0);
    byte_out(8'h5A);
    byte_out(8'hC3);
    chk(spi_so_en == 1'b0, "R1", "so_en during dummies", spi_so_en, 0);
    spi_si = 1'b0;
    #HALF; spi_sck = 1'b1;
    #HALF; spi_sck = 1'b0;
    for (int i = 0; i < 7; i++) bit_out(1'b1);
    if (expect_data) begin
      for (int k = 0; k < nread; k++) exp_q.push_back(sig_value);
      rd_active = 1'b1;
      for (int k = 0; k < nread * 8; k++) bit_out(1'b0);
      rd_active = 1'b0;
      chk(exp_q.size() == 0, "R3", "all signature bytes seen", exp_q.size(), 0);
    end else begin
      for (int k = 0; k < nread * 8; k++) bit_out(1'b0);
      chk(spi_so_en == 1'b0, "R8", "no output when busy", spi_so_en, 0);
    end
    cs_high();
  endtask

  task automatic pulse_fails();
    @(negedge clk);
    erase_fail_set = 1'b1; prog_fail_set = 1'b1;
    @(negedge clk);
    erase_fail_set = 1'b0; prog_fail_set = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1ns;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // reset state (R4, R1)
    chk(power_down_o == 1'b0, "R4", "pd after reset", power_down_o, 0);
    chk(spi_so_en == 1'b0, "R1", "so_en after reset", spi_so_en, 0);
    chk(status_o[6:5] == 2'b00, "R9", "flags after reset", status_o[6:5], 0);

    // R7: signature in standby, repeated (R2, R3), no wake pulse
    res_frame(3, 1'b1);
    chk(done_cnt == 0, "R7", "no wake pulse in standby", done_cnt, 0);
    chk(power_down_o == 1'b0, "R7", "still standby", power_down_o, 0);

    // R9: clear flags, WEL kept
    wel_i = 1'b1;
    pulse_fails();
    chk(status_o[6:5] == 2'b11, "R9", "flags set", status_o[6:5], 3);
    cmd(8'h30);
    chk(status_o[6:5] == 2'b00, "R9", "flags cleared", status_o[6:5], 0);
    chk(status_o[1] == 1'b1, "R9", "WEL unchanged", status_o[1], 1);

    // R10: abort after 4 opcode bits of 0xB9
    cs_low();
    for (int i = 7; i >= 4; i--) bit_out(1'(8'hB9 >> i));
    cs_high();
    chk(power_down_o == 1'b0, "R10", "pd after aborted opcode", power_down_o, 0);

    // R11: unknown opcode
    pulse_fails();
    cmd(8'h05);
    chk(power_down_o == 1'b0, "R11", "pd after unknown opcode", power_down_o, 0);
    chk(status_o[6:5] == 2'b11, "R11", "flags after unknown opcode", status_o[6:5], 3);
    chk(spi_so_en == 1'b0, "R11", "so_en after unknown opcode", spi_so_en, 0);

    // R8: busy blocks all three
    busy_i = 1'b1;
    cmd(8'hB9);
    chk(power_down_o == 1'b0, "R8", "pd entry blocked when busy", power_down_o, 0);
    cmd(8'h30);
    chk(status_o[6:5] == 2'b11, "R8", "clear blocked when busy", status_o[6:5], 3);
    res_frame(1, 1'b0);
    busy_i = 1'b0;

    // R4: enter deep power-down
    cmd(8'hB9);
    chk(power_down_o == 1'b1, "R4", "pd after 0xB9", power_down_o, 1);

    // R5: other opcodes ignored in power-down
    cmd(8'h30);
    chk(status_o[6:5] == 2'b11, "R5", "clear ignored in pd", status_o[6:5], 3);
    cmd(8'h05);
    chk(power_down_o == 1'b1, "R5", "pd kept", power_down_o, 1);

    // R6: release with signature, timed wake
    sig_value = 8'hC5;
    res_frame(2, 1'b1);
    chk(power_down_o == 1'b1, "R6", "pd just after release", power_down_o, 1);
    while (cycle < cs_cycle + WAKE / 2) @(negedge clk);
    chk(power_down_o == 1'b1 && wake_busy_o == 1'b1, "R6", "pd mid delay",
        power_down_o, 1);
    for (int w = 0; w < WAKE * 4 && done_cnt == 0; w++) @(negedge clk);
    chk(done_cnt == 1, "R6", "wake_done pulses", done_cnt, 1);
    chk((done_cycle - cs_cycle) >= WAKE && (done_cycle - cs_cycle) <= WAKE + 6,
        "R6", "wake delay cycles", done_cycle - cs_cycle, WAKE);
    @(negedge clk);
    chk(power_down_o == 1'b0, "R6", "standby after delay", power_down_o, 0);
    chk(wake_done_o == 1'b0, "R6", "done is one cycle", wake_done_o, 0);

    // R8: release blocked by busy while in power-down
    cmd(8'hB9);
    busy_i = 1'b1;
    res_frame(1, 1'b0);
    repeat (WAKE + 20) @(negedge clk);
    chk(power_down_o == 1'b1, "R8", "pd kept when busy", power_down_o, 1);
    chk(done_cnt == 1, "R8", "no wake pulse when busy", done_cnt, 1);
    busy_i = 1'b0;
    res_frame(1, 1'b1);
    repeat (WAKE + 20) @(negedge clk);
    chk(power_down_o == 1'b0, "R6", "second wake", power_down_o, 0);
    chk(done_cnt == 2, "R6", "second wake pulse", done_cnt, 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2ms;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule